// File: doc/BRIEF.md
# Programmable Clock Output Divider

This block drives a single clock output pin from a fast source clock. Software controls it through one 8-bit mode register that it reaches over a simple bus port. The register holds an output-enable bit and a 3-bit divide code. The codes select the source clock divided by 1, 2, 4, 8 or 16, and the source clock passes straight through for divide-by-one. While the block is disabled, or when the code is one of the three prohibited values, the pin stays low.

The register can be written as a whole byte or one bit at a time, and any single bit can be read back on its own. Software must stop the output before it changes the divide code. The hardware enforces this rule: a write to the select bits has no effect while the enable bit is set. The register lives in the bus clock domain. Its contents are carried into the source clock domain through a synchronizer. There, a free-running counter produces the divided clocks. Starting and stopping are aligned to the selected clock's low phase, so the pin never shows a shortened high or low pulse.

Top module: `pclk_out_top`

## Requirements
- R1: After reset the register reads 0x01 (output disabled, divide code 001) and `clk_out` is low.
- R2: Register bits 7, 6, 5 and 3 always read 0, and writes to them (byte or single-bit) have no effect.
- R3: A byte write (`reg_we`=1, `reg_bit_mode`=0) loads bit 4 (enable) from `reg_wdata[4]`. When the enable bit was 0 before the write, it also loads bits 2..0 (divide code) from `reg_wdata[2:0]`.
- R4: A single-bit write (`reg_we`=1, `reg_bit_mode`=1) writes `reg_wdata[0]` into bit `reg_bit_idx` of the register, subject to R2 and R5. `reg_rbit` always shows register bit `reg_bit_idx`.
- R5: While the enable bit is 1, writes to bits 2..0 are ignored and the old code is kept.
- R6: While the enable bit is 0, `clk_out` is held low once the stop has taken effect.
- R7: With the block enabled, codes 000, 001, 010, 011 and 100 give `clk_out` equal to the source clock divided by 1, 2, 4, 8 and 16 respectively. Divided outputs have a 50 % duty cycle.
- R8: Codes 101, 110 and 111 keep `clk_out` low even when enabled, and they read back as written.
- R9: Enabling and disabling produce no runt pulses. After enable, the first high phase is preceded by at least a full low phase and lasts a full half period. After disable, the last high phase runs to full length and the output then stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register interface clock |
| bus_rst_n | input | 1 | Asynchronous active-low reset, bus domain |
| src_clk | input | 1 | Source clock to be divided |
| src_rst_n | input | 1 | Asynchronous active-low reset, source domain |
| reg_we | input | 1 | Write strobe for the mode register |
| reg_bit_mode | input | 1 | 1 = single-bit access, 0 = byte access |
| reg_bit_idx | input | 3 | Bit index for single-bit write and read |
| reg_wdata | input | 8 | Write data; bit 0 carries the value in bit mode |
| reg_rdata | output | 8 | Register contents |
| reg_rbit | output | 1 | Register bit selected by `reg_bit_idx` |
| clk_out | output | 1 | Divided / gated clock output |

## Verification
The source-domain assertions assume that the enable and code values at the synchronizer output only change in ways the bus side allows. In particular, the code moves only while the enable is low. They also assume the source clock runs freely once reset is released. The stimulus respects this by issuing every code change as a write while the block is disabled. Some writes try to change the code while it is enabled; the register filter drops those, so the synchronized code still never moves under a running output. The bench ties both clocks to one 200 MHz source. This keeps the crossing latency fixed while the waveform checks measure whole phases, not absolute cycle positions.

// File: rtl/pclk_pkg.sv
package pclk_pkg;

    localparam int REG_W  = 8;
    localparam int SEL_W  = 3;
    localparam int CNT_W  = 4;
    localparam int EN_BIT = 4;

    localparam logic [SEL_W-1:0] SEL_RST = 3'd1;

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
    } pclk_ctl_t;

    localparam int CTL_W = $bits(pclk_ctl_t);

    localparam pclk_ctl_t CTL_RST = '{en: 1'b0, sel: SEL_RST};

    // a code is usable when it names a counter tap or the pass-through
    function automatic logic sel_ok(input logic [SEL_W-1:0] s);
        return int'(s) <= CNT_W;
    endfunction

endpackage

// File: rtl/pclk_regif.sv
module pclk_regif
    import pclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             bit_mode,
    input  logic [2:0]       bit_idx,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic             rbit,
    output pclk_ctl_t        ctl
);

    pclk_ctl_t        ctl_d, ctl_q;
    logic [REG_W-1:0] img, cand, wmask, merged;

    always_comb begin
        img                = '0;
        img[EN_BIT]        = ctl_q.en;
        img[SEL_W-1:0]     = ctl_q.sel;

        // candidate byte: whole write, or current image with one bit replaced
        cand = wdata;
        if (bit_mode) begin
            cand          = img;
            cand[bit_idx] = wdata[0];
        end

        // enable is always writable, code only while stopped
        wmask            = '0;
        wmask[EN_BIT]    = 1'b1;
        wmask[SEL_W-1:0] = {SEL_W{~ctl_q.en}};

        merged = (cand & wmask) | (img & ~wmask);

        ctl_d = ctl_q;
        if (we) begin
            ctl_d.en  = merged[EN_BIT];
            ctl_d.sel = merged[SEL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign rdata = img;
    assign rbit  = img[bit_idx];
    assign ctl   = ctl_q;

endmodule

// File: rtl/pclk_sync.sv
module pclk_sync #(
    parameter int             W      = 4,
    parameter int             STAGES = 2,
    parameter logic [W-1:0]   RST    = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= RST;
                else        stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/pclk_divgate.sv
module pclk_divgate
    import pclk_pkg::*;
#(
    parameter int DIV_W = CNT_W
) (
    input  logic             src_clk,
    input  logic             src_rst_n,
    input  pclk_ctl_t        ctl_s,
    output logic             clk_out,
    output logic             run_o,
    output logic             en_use_o,
    output logic [SEL_W-1:0] sel_o,
    output logic [DIV_W-1:0] cnt_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             run;
        logic             en_dly;
        logic [SEL_W-1:0] sel;
    } dg_st_t;

    dg_st_t           st_d, st_q;
    logic [DIV_W-1:0] cnt_inc;
    logic             en_use, code_ok, pass_sel, tap_now, tap_next, gate_lat;

    always_comb begin
        st_d     = st_q;
        cnt_inc  = st_q.cnt + 1'b1;
        // extra stage on enable lets a code written with it settle first
        en_use   = ctl_s.en & st_q.en_dly;
        code_ok  = sel_ok(st_q.sel);
        pass_sel = (st_q.sel == '0);

        tap_now  = 1'b0;
        tap_next = 1'b0;
        for (int k = 1; k <= DIV_W; k++) begin
            if (st_q.sel == SEL_W'(k)) begin
                tap_now  = st_q.cnt[k-1];
                tap_next = cnt_inc[k-1];
            end
        end

        st_d.en_dly = ctl_s.en;

        if (!st_q.run) begin
            st_d.run = en_use && (st_q.sel == ctl_s.sel);
        end else if (!en_use) begin
            // keep going until the running high phase has finished
            st_d.run = (!pass_sel && code_ok) ? tap_next : 1'b0;
        end

        st_d.cnt = st_q.run ? cnt_inc : '0;
        st_d.sel = st_q.run ? st_q.sel : ctl_s.sel;
    end

    always_ff @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n) begin
            st_q.cnt    <= '0;
            st_q.run    <= 1'b0;
            st_q.en_dly <= 1'b0;
            st_q.sel    <= SEL_RST;
        end else begin
            st_q <= st_d;
        end
    end

    // pass-through gate: opens and closes only during the low phase
    always_latch begin
        if (!src_clk) gate_lat = st_q.run & pass_sel;
    end

    always_comb begin
        if (pass_sel) clk_out = src_clk & gate_lat;
        else          clk_out = code_ok & tap_now;
    end

    assign run_o    = st_q.run;
    assign en_use_o = en_use;
    assign sel_o    = st_q.sel;
    assign cnt_o    = st_q.cnt;

endmodule

// File: rtl/pclk_out_top.sv
module pclk_out_top
    import pclk_pkg::*;
(
    input  logic             bus_clk,
    input  logic             bus_rst_n,
    input  logic             src_clk,
    input  logic             src_rst_n,
    input  logic             reg_we,
    input  logic             reg_bit_mode,
    input  logic [2:0]       reg_bit_idx,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             reg_rbit,
    output logic             clk_out
);

    pclk_ctl_t        ctl_bus, ctl_src;
    logic [CTL_W-1:0] ctl_src_raw;
    logic             run_w, en_use_w;
    logic [SEL_W-1:0] sel_w;
    logic [CNT_W-1:0] cnt_w;

    pclk_regif u_regif (
        .clk      (bus_clk),
        .rst_n    (bus_rst_n),
        .we       (reg_we),
        .bit_mode (reg_bit_mode),
        .bit_idx  (reg_bit_idx),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .rbit     (reg_rbit),
        .ctl      (ctl_bus)
    );

    pclk_sync #(
        .W      (CTL_W),
        .STAGES (2),
        .RST    (CTL_RST)
    ) u_sync (
        .clk   (src_clk),
        .rst_n (src_rst_n),
        .d     (ctl_bus),
        .q     (ctl_src_raw)
    );

    assign ctl_src = pclk_ctl_t'(ctl_src_raw);

    pclk_divgate #(
        .DIV_W (CNT_W)
    ) u_divgate (
        .src_clk   (src_clk),
        .src_rst_n (src_rst_n),
        .ctl_s     (ctl_src),
        .clk_out   (clk_out),
        .run_o     (run_w),
        .en_use_o  (en_use_w),
        .sel_o     (sel_w),
        .cnt_o     (cnt_w)
    );

endmodule

// File: rtl/pclk_out_chk.sv
module pclk_out_chk
    import pclk_pkg::*;
(
    input logic             bus_clk,
    input logic             bus_rst_n,
    input logic             src_clk,
    input logic             src_rst_n,
    input logic [REG_W-1:0] reg_rdata,
    input logic             run,
    input logic             en_use,
    input logic [SEL_W-1:0] sel,
    input logic [CNT_W-1:0] cnt,
    input logic             clk_out
);

    AST_RESV_ZERO: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        reg_rdata[7:5] == 3'b000 && !reg_rdata[3]); // R2

    AST_SEL_LOCKED: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        reg_rdata[EN_BIT] |=> reg_rdata[SEL_W-1:0] == $past(reg_rdata[SEL_W-1:0])); // R5

    AST_IDLE_CLEARS_CNT: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        !run |=> cnt == '0); // R6

    AST_BAD_CODE_LOW: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        !sel_ok(sel) |-> !clk_out); // R8

    AST_SEL_FROZEN_RUN: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        run |=> $stable(sel)); // R9

    AST_START_NEEDS_EN: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        $rose(run) |-> $past(en_use)); // R9

endmodule

bind pclk_out_top pclk_out_chk u_chk (
    .bus_clk   (bus_clk),
    .bus_rst_n (bus_rst_n),
    .src_clk   (src_clk),
    .src_rst_n (src_rst_n),
    .reg_rdata (reg_rdata),
    .run       (run_w),
    .en_use    (en_use_w),
    .sel       (sel_w),
    .cnt       (cnt_w),
    .clk_out   (clk_out)
);

// File: tb/tb_pclk_out_top.sv
`timescale 1ns/1ps
module tb_pclk_out_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       we, bmode;
    logic [2:0] bidx;
    logic [7:0] wdata, rdata;
    logic       rbit, clk_out;

    always #2.5 clk = ~clk;

    pclk_out_top dut (
        .bus_clk      (clk),
        .bus_rst_n    (rst_n),
        .src_clk      (clk),
        .src_rst_n    (rst_n),
        .reg_we       (we),
        .reg_bit_mode (bmode),
        .reg_bit_idx  (bidx),
        .reg_wdata    (wdata),
        .reg_rdata    (rdata),
        .reg_rbit     (rbit),
        .clk_out      (clk_out)
    );

    int   nvec  = 0;
    int   nfail = 0;
    logic [7:0] mdl;
    logic samp [0:159];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // behavioural register model, compared every clock
    always @(posedge clk) begin
        if (!rst_n) begin
            mdl = 8'h01;
        end else if (we) begin
            if (!bmode) begin
                if (!mdl[4]) mdl[2:0] = wdata[2:0];
                mdl[4] = wdata[4];
            end else if (bidx == 3'd4) begin
                mdl[4] = wdata[0];
            end else if (bidx <= 3'd2 && !mdl[4]) begin
                mdl[bidx] = wdata[0];
            end
        end
        #2;
        if (rst_n) begin
            chk(rdata === mdl, "R3 register image", rdata, mdl);
            chk((rdata & 8'hE8) === 8'h00, "R2 reserved bits", rdata & 8'hE8, 0);
            chk(rbit === mdl[bidx], "R4 bit read", rbit, mdl[bidx]);
        end
    end

    task automatic wr_byte(input logic [7:0] v);
        @(negedge clk);
        we = 1'b1; bmode = 1'b0; wdata = v;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic wr_bit(input logic [2:0] idx, input logic v);
        @(negedge clk);
        we = 1'b1; bmode = 1'b1; bidx = idx; wdata = {7'd0, v};
        @(negedge clk);
        we = 1'b0; bmode = 1'b0;
    endtask

    task automatic capture(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            samp[i] = clk_out;
        end
    endtask

    task automatic check_zero(input int n, input string tag);
        int ones = 0;
        capture(n);
        for (int i = 0; i < n; i++) if (samp[i] !== 1'b0) ones++;
        chk(ones == 0, tag, ones, 0);
    endtask

    task automatic check_steady(input int code);
        int p = 1 << code;
        int i0 = -1;
        int bad = 0;
        capture(64);
        if (p == 1) begin
            for (int i = 0; i < 64; i++) if (samp[i] !== 1'b1) bad++;
            chk(bad == 0, "R7 pass-through", bad, 0);
        end else begin
            for (int i = 1; i < 64; i++)
                if (i0 < 0 && samp[i] === 1'b1 && samp[i-1] === 1'b0) i0 = i;
            chk(i0 > 0 && i0 <= p, "R7 rising edge found", i0, p);
            if (i0 > 0)
                for (int j = i0; j < 64; j++)
                    if (samp[j] !== (((j - i0) % p) < p / 2)) bad++;
            chk(bad == 0, "R7 divided waveform", bad, 0);
        end
    endtask

    task automatic check_start(input int code);
        int p = 1 << code;
        int f = -1;
        int h = 0;
        int l = 0;
        fork
            wr_byte(8'h10 | 8'(code));
            capture(100);
        join
        for (int i = 0; i < 100; i++) if (f < 0 && samp[i] === 1'b1) f = i;
        if (p == 1) begin
            chk(samp[0] === 1'b0 && samp[99] === 1'b1, "R9 pass-through start", samp[99], 1);
        end else begin
            chk(f >= p / 2, "R9 low phase before first high", f, p / 2);
            if (f >= 0) begin
                for (int i = f; i < 100 && samp[i] === 1'b1; i++) h++;
                for (int i = f + h; i < 100 && samp[i] === 1'b0; i++) l++;
            end
            chk(h == p / 2, "R9 first high phase length", h, p / 2);
            chk(l == p / 2, "R9 first low phase length", l, p / 2);
        end
    endtask

    task automatic check_stop(input int code);
        int p = 1 << code;
        int bad = 0;
        int tail = 0;
        fork
            wr_byte(8'(code));
            capture(100);
        join
        for (int i = 60; i < 100; i++) if (samp[i] !== 1'b0) tail++;
        chk(tail == 0, "R6 output low after disable", tail, 0);
        if (p > 1) begin
            for (int i = 1; i < 60; i++) begin
                if (samp[i] === 1'b1 && samp[i-1] === 1'b0) begin
                    int h = 0;
                    for (int j = i; j < 100 && samp[j] === 1'b1; j++) h++;
                    if (h != p / 2) bad++;
                end
            end
            chk(bad == 0, "R9 last high phase full length", bad, 0);
        end
    endtask

    initial begin
        #(200000 * 5);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; we = 1'b0; bmode = 1'b0; bidx = 3'd0; wdata = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(rdata === 8'h01, "R1 reset value", rdata, 8'h01);
        check_zero(20, "R1 output low after reset");

        // all-ones write: reserved ignored, prohibited code enabled
        wr_byte(8'hFF);
        #1;
        chk(rdata === 8'h17, "R8 prohibited code reads back", rdata, 8'h17);
        check_zero(40, "R8 prohibited code keeps output low");

        // disable with a code change attempt: code must stay 111
        wr_byte(8'h02);
        #1;
        chk(rdata === 8'h07, "R5 code kept on disabling write", rdata, 8'h07);
        check_zero(20, "R6 disabled output low");

        for (int c = 0; c <= 4; c++) begin
            wr_byte(8'(c));
            repeat (4) @(negedge clk);
            check_zero(10, "R6 low while disabled with code set");
            check_start(c);
            check_steady(c);
            check_stop(c);
        end

        // single-bit accesses; code is 100 and block is off
        wr_bit(3'd4, 1'b1);
        wr_bit(3'd0, 1'b1);
        #1;
        chk(rdata === 8'h14, "R5 bit write to code ignored while on", rdata, 8'h14);
        repeat (8) @(negedge clk);
        check_steady(4);
        wr_bit(3'd4, 1'b0);
        wr_bit(3'd0, 1'b1);
        wr_bit(3'd6, 1'b1);
        wr_bit(3'd3, 1'b1);
        #1;
        chk(rdata === 8'h05, "R4 bit writes applied, R2 reserved ignored", rdata, 8'h05);
        @(negedge clk); bidx = 3'd2;
        #1;
        chk(rbit === 1'b1, "R4 bit read of bit 2", rbit, 1);
        @(negedge clk); bidx = 3'd6;
        #1;
        chk(rbit === 1'b0, "R2 reserved bit reads zero", rbit, 0);
        wr_bit(3'd4, 1'b1);
        repeat (8) @(negedge clk);
        check_zero(40, "R8 code 101 enabled stays low");
        wr_bit(3'd4, 1'b0);
        wr_byte(8'h16);
        #1;
        chk(rdata === 8'h16, "R8 code 110 reads back", rdata, 8'h16);
        repeat (8) @(negedge clk);
        check_zero(30, "R8 code 110 enabled stays low");

        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule